// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit sits between a 32-bit processor's execute stage and its data memory port. It forms the effective address of every memory access. The address is the base register plus a sign-extended immediate displacement, or the base register plus an index register. For stores it places the source register's low bits on the byte lanes the address selects and raises byte-enable strobes for exactly those lanes. For loads it picks the addressed lanes out of the 32-bit read word and widens them to 32 bits, with zero fill or with the sign of the loaded value.

Each access is checked against the alignment rule for its size. A misaligned access raises a fault flag in the same cycle and writes nothing. The address, write data, strobes and fault flag are combinational from the request. The memory is expected to return the read word in that same cycle. The widened load result is registered and appears one cycle later with a response-valid pulse.

Top module: `lsu_lane_align`

## Requirements
- R1: `mem_addr` equals `base_val + index_val` when `req_use_index` is 1, and `base_val` plus `imm_disp` sign-extended to 32 bits when it is 0. It is combinational in the request cycle.
- R2: `align_fault` is 1 exactly when `req_valid` is 1 and the access is misaligned. An access is misaligned when it is a halfword (size code 1) with address bit 0 set, a word (size code 2) with either of address bits 1:0 set, or uses the reserved size code 3. Bytes (size code 0) never fault.
- R3: A legal byte store drives `mem_addr`'s byte offset lane only: `mem_be = 1 << addr[1:0]`. `mem_wdata` repeats `store_src[7:0]` on all four lanes. Lane k is bits 8k+7:8k, so the order is little-endian.
- R4: A legal halfword store drives `mem_be = 4'b0011` when address bit 1 is 0 and `4'b1100` when it is 1. `mem_wdata` repeats `store_src[15:0]` in both halves.
- R5: A legal word store drives `mem_be = 4'b1111` and `mem_wdata = store_src`.
- R6: `mem_be` is zero whenever `req_valid` is 0, the request is a load, or `align_fault` is 1.
- R7: A legal byte load returns lane `addr[1:0]` of `mem_rdata` in `rsp_data[7:0]`. The upper 24 bits are copies of that byte's bit 7 when `req_signed` is 1, and zero otherwise.
- R8: A legal halfword load returns bits 31:16 of `mem_rdata` when address bit 1 is 1, and bits 15:0 otherwise. The upper 16 bits are sign- or zero-filled as selected by `req_signed`.
- R9: A legal word load returns `mem_rdata` unchanged, whatever `req_signed` is.
- R10: `rsp_valid` is 1 in the cycle after a load request and 0 after any other cycle. For a faulted load, `rsp_fault` is 1 and `rsp_data` is zero.
- R11: While `rst_n` is low at a clock edge, `rsp_valid`, `rsp_fault` and `rsp_data` are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_signed | input | 1 | Sign-extend sub-word loads |
| req_use_index | input | 1 | 1 = base + index, 0 = base + immediate |
| base_val | input | 32 | Base register value |
| index_val | input | 32 | Index register value |
| imm_disp | input | 12 | Signed immediate displacement |
| store_src | input | 32 | Store source register value |
| mem_rdata | input | 32 | Memory read word for the current address |
| mem_addr | output | 32 | Effective byte address |
| mem_wdata | output | 32 | Lane-placed store data |
| mem_be | output | 4 | Byte-lane write strobes |
| align_fault | output | 1 | Current access is misaligned |
| rsp_valid | output | 1 | Load result valid |
| rsp_fault | output | 1 | Load result came from a faulted access |
| rsp_data | output | 32 | Widened load result |

## Verification
The bench builds the unit with its default widths: a 32-bit data path, a 32-bit address and a 12-bit displacement. With those widths the whole decision space is small enough to sweep completely. It covers every size code including the reserved one, all four byte offsets, both sign modes, load and store, and both addressing modes, each against several data words that carry set and clear sign bits on different lanes. The displacement values include the most positive and most negative 12-bit immediates, and the index values are negative, so carry and borrow in the adder are exercised. Idle cycles with misaligned addresses confirm that nothing is flagged or strobed without a request.

// File: rtl/lsu_lane_pkg.sv
// Shared encodings for the load/store lane unit.
// Assumes byte-granular lanes and a 32-bit word.
package lsu_lane_pkg;
    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2,
        ACC_RSVD = 2'd3
    } acc_size_e;

    localparam int LANE_W = 8;
endpackage

// File: rtl/lsu_agu.sv
// Effective address generator: base plus sign-extended immediate,
// or base plus index register. Assumes ADDR_W > IMM_W.
module lsu_agu #(
    parameter int ADDR_W = 32,
    parameter int IMM_W  = 12
) (
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] index_val,
    input  logic [IMM_W-1:0]  imm_disp,
    input  logic              use_index,
    output logic [ADDR_W-1:0] eff_addr
);
    localparam int EXT_W = ADDR_W - IMM_W;

    logic [ADDR_W-1:0] imm_ext;

    // Widen the displacement with its sign bit.
    always_comb begin
        imm_ext = {{EXT_W{imm_disp[IMM_W-1]}}, imm_disp};
    end

    // Select the offset operand and add it to the base.
    always_comb begin
        eff_addr = base_val + (use_index ? index_val : imm_ext);
    end
endmodule

// File: rtl/lsu_align_chk.sv
// Size-dependent alignment test on the low address bits.
// Reserved size code is always reported as misaligned.
module lsu_align_chk
    import lsu_lane_pkg::*;
#(
    parameter int OFF_W = 2
) (
    input  acc_size_e        size,
    input  logic [OFF_W-1:0] off,
    output logic             misaligned
);
    // Decide whether the offset violates the size's natural boundary.
    always_comb begin
        unique case (size)
            ACC_BYTE: misaligned = 1'b0;
            ACC_HALF: misaligned = off[0];
            ACC_WORD: misaligned = |off[1:0];
            default:  misaligned = 1'b1;
        endcase
    end
endmodule

// File: rtl/lsu_store_lane.sv
// Store lane placement: replicates sub-word data across every lane
// it could occupy and raises strobes on the addressed lanes only.
// Assumes little-endian lanes (lane k = bits 8k+7:8k).
module lsu_store_lane
    import lsu_lane_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  acc_size_e                      size,
    input  logic [$clog2(DATA_W/LANE_W)-1:0] off,
    input  logic                           enable,
    input  logic [DATA_W-1:0]              src,
    output logic [DATA_W-1:0]              wdata,
    output logic [DATA_W/LANE_W-1:0]       be
);
    localparam int LANES = DATA_W / LANE_W;
    localparam int OFF_W = $clog2(LANES);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [OFF_W-1:0] LANE_ID = OFF_W'(i);
        localparam int HALF_SRC = (i % 2) * LANE_W;

        logic hit;

        // Pick the source byte that lands on this lane.
        always_comb begin
            unique case (size)
                ACC_BYTE: wdata[i*LANE_W +: LANE_W] = src[0 +: LANE_W];
                ACC_HALF: wdata[i*LANE_W +: LANE_W] = src[HALF_SRC +: LANE_W];
                default:  wdata[i*LANE_W +: LANE_W] = src[i*LANE_W +: LANE_W];
            endcase
        end

        // Decide whether this lane is covered by the access.
        always_comb begin
            unique case (size)
                ACC_BYTE: hit = (off == LANE_ID);
                ACC_HALF: hit = (off[OFF_W-1:1] == LANE_ID[OFF_W-1:1]);
                ACC_WORD: hit = 1'b1;
                default:  hit = 1'b0;
            endcase
        end

        // Gate the strobe by the legal-store enable.
        always_comb begin
            be[i] = enable & hit;
        end
    end
endmodule

// File: rtl/lsu_load_extract.sv
// Load lane extraction: selects the addressed byte or halfword from
// the read word and zero- or sign-extends it to the full width.
// Assumes little-endian lanes; offset is taken as already aligned.
module lsu_load_extract
    import lsu_lane_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  acc_size_e                        size,
    input  logic [$clog2(DATA_W/LANE_W)-1:0] off,
    input  logic                             sign_en,
    input  logic [DATA_W-1:0]                rdata,
    output logic [DATA_W-1:0]                ext
);
    localparam int LANES  = DATA_W / LANE_W;
    localparam int HALF_W = 2 * LANE_W;

    logic [LANE_W-1:0] lane [LANES];
    logic [LANE_W-1:0] byte_v;
    logic [HALF_W-1:0] half_v;

    for (genvar i = 0; i < LANES; i++) begin : g_split
        assign lane[i] = rdata[i*LANE_W +: LANE_W];
    end

    // Select the addressed byte and the halfword pair.
    always_comb begin
        byte_v = lane[off];
        half_v = {lane[{off[$bits(off)-1:1], 1'b1}], lane[{off[$bits(off)-1:1], 1'b0}]};
    end

    // Widen to the full data width.
    always_comb begin
        unique case (size)
            ACC_BYTE: ext = {{(DATA_W-LANE_W){sign_en & byte_v[LANE_W-1]}}, byte_v};
            ACC_HALF: ext = {{(DATA_W-HALF_W){sign_en & half_v[HALF_W-1]}}, half_v};
            ACC_WORD: ext = rdata;
            default:  ext = '0;
        endcase
    end
endmodule

// File: rtl/lsu_lane_align.sv
// Load/store byte-lane alignment unit. Address, store lanes, strobes
// and fault are combinational from the request; the memory returns
// mem_rdata in the request cycle; the load result is registered.
module lsu_lane_align
    import lsu_lane_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IMM_W  = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic                       req_store,
    input  logic [1:0]                 req_size,
    input  logic                       req_signed,
    input  logic                       req_use_index,
    input  logic [ADDR_W-1:0]          base_val,
    input  logic [ADDR_W-1:0]          index_val,
    input  logic [IMM_W-1:0]           imm_disp,
    input  logic [DATA_W-1:0]          store_src,
    input  logic [DATA_W-1:0]          mem_rdata,
    output logic [ADDR_W-1:0]          mem_addr,
    output logic [DATA_W-1:0]          mem_wdata,
    output logic [DATA_W/LANE_W-1:0]   mem_be,
    output logic                       align_fault,
    output logic                       rsp_valid,
    output logic                       rsp_fault,
    output logic [DATA_W-1:0]          rsp_data
);
    localparam int LANES = DATA_W / LANE_W;
    localparam int OFF_W = $clog2(LANES);

    acc_size_e         size;
    logic [ADDR_W-1:0] eff_addr;
    logic              misaligned;
    logic              store_en;
    logic              load_req;
    logic [DATA_W-1:0] load_ext;

    // Decode the size field and qualify the request.
    always_comb begin
        size     = acc_size_e'(req_size);
        store_en = req_valid & req_store & ~misaligned;
        load_req = req_valid & ~req_store;
    end

    lsu_agu #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_agu (
        .base_val  (base_val),
        .index_val (index_val),
        .imm_disp  (imm_disp),
        .use_index (req_use_index),
        .eff_addr  (eff_addr)
    );

    lsu_align_chk #(.OFF_W(OFF_W)) u_align (
        .size       (size),
        .off        (eff_addr[OFF_W-1:0]),
        .misaligned (misaligned)
    );

    lsu_store_lane #(.DATA_W(DATA_W)) u_store (
        .size   (size),
        .off    (eff_addr[OFF_W-1:0]),
        .enable (store_en),
        .src    (store_src),
        .wdata  (mem_wdata),
        .be     (mem_be)
    );

    lsu_load_extract #(.DATA_W(DATA_W)) u_load (
        .size    (size),
        .off     (eff_addr[OFF_W-1:0]),
        .sign_en (req_signed),
        .rdata   (mem_rdata),
        .ext     (load_ext)
    );

    // Drive the combinational request-side outputs.
    always_comb begin
        mem_addr    = eff_addr;
        align_fault = req_valid & misaligned;
    end

    // Register the load response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= load_req;
            if (load_req) begin
                rsp_fault <= misaligned;
                rsp_data  <= misaligned ? '0 : load_ext;
            end
        end
    end
endmodule

// File: rtl/lsu_lane_align_chk.sv
// Property checker for the lane alignment unit, bound to the top.
module lsu_lane_align_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LANES  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_store,
    input logic [1:0]        req_size,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_rdata,
    input logic [LANES-1:0]  mem_be,
    input logic              align_fault,
    input logic              rsp_valid,
    input logic              rsp_fault,
    input logic [DATA_W-1:0] rsp_data
);
    // R6
    strobe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_be != '0) |-> (req_valid && req_store && !align_fault));

    // R2
    word_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'd2 && mem_addr[1:0] != 2'b00) |-> align_fault);

    // R3
    byte_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store && req_size == 2'd0) |-> ($countones(mem_be) == 1));

    // R4
    half_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store && req_size == 2'd1 && !align_fault)
            |-> (mem_be == 4'b0011 || mem_be == 4'b1100));

    // R10
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_store) |=> rsp_valid);

    // R10
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_store) |=> !rsp_valid);

    // R10
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_data == '0));

    // R9
    word_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_store && req_size == 2'd2 && !align_fault)
            |=> (rsp_data == $past(mem_rdata)));
endmodule

bind lsu_lane_align lsu_lane_align_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LANES  (LANES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_store   (req_store),
    .req_size    (req_size),
    .mem_addr    (mem_addr),
    .mem_rdata   (mem_rdata),
    .mem_be      (mem_be),
    .align_fault (align_fault),
    .rsp_valid   (rsp_valid),
    .rsp_fault   (rsp_fault),
    .rsp_data    (rsp_data)
);

// File: tb/lsu_lane_align_tb.sv
// Exhaustive sweep bench for the lane alignment unit.
module lsu_lane_align_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_store = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic        req_signed = 1'b0;
    logic        req_use_index = 1'b0;
    logic [31:0] base_val = '0;
    logic [31:0] index_val = '0;
    logic [11:0] imm_disp = '0;
    logic [31:0] store_src = '0;
    logic [31:0] mem_rdata = '0;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_be;
    logic        align_fault;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [31:0] rsp_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lsu_lane_align u_dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit exp_misal(input int sz, input int off);
        case (sz)
            0: return 1'b0;
            1: return (off % 2) != 0;
            2: return off != 0;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [31:0] exp_load(input int sz, input int off, input bit sg, input logic [31:0] rd);
        logic [31:0] v;
        if (sz == 0) begin
            v = (rd >> (8 * off)) & 32'hFF;
            if (sg && v >= 32'h80) v = v | 32'hFFFF_FF00;
        end else if (sz == 1) begin
            v = (rd >> (16 * (off / 2))) & 32'hFFFF;
            if (sg && v >= 32'h8000) v = v | 32'hFFFF_0000;
        end else begin
            v = rd;
        end
        return v;
    endfunction

    initial begin
        logic [31:0] rd_pat [3];
        logic [31:0] src_pat [3];
        logic [11:0] imm_pat [3];
        rd_pat  = '{32'h80FF_7F01, 32'h7F01_80FE, 32'hC3A5_5A3C};
        src_pat = '{32'hDEAD_BEEF, 32'h1234_5678, 32'h00FF_80AA};
        imm_pat = '{12'hFF8, 12'h7FF, 12'h800};

        // R11: reset state
        repeat (3) @(posedge clk);
        #2;
        chk(rsp_valid == 1'b0, "R11 rsp_valid", 32'(rsp_valid), 0);
        chk(rsp_fault == 1'b0, "R11 rsp_fault", 32'(rsp_fault), 0);
        chk(rsp_data == '0, "R11 rsp_data", rsp_data, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 / R6: idle cycle with a misaligned word address
        req_valid = 1'b0; req_store = 1'b1; req_size = 2'd2;
        base_val = 32'h0000_1003; req_use_index = 1'b1; index_val = '0;
        #1;
        chk(align_fault == 1'b0, "R2 idle fault", 32'(align_fault), 0);
        chk(mem_be == 4'b0, "R6 idle strobes", 32'(mem_be), 0);
        @(posedge clk); #2;
        chk(rsp_valid == 1'b0, "R10 idle no rsp", 32'(rsp_valid), 0);

        for (int sz = 0; sz < 4; sz++)
        for (int off = 0; off < 4; off++)
        for (int sg = 0; sg < 2; sg++)
        for (int st = 0; st < 2; st++)
        for (int p = 0; p < 3; p++)
        for (int md = 0; md < 2; md++) begin
            logic [31:0] ea;
            logic [31:0] imm_ext;
            logic [31:0] exp_wd;
            logic [3:0]  exp_be;
            bit          mis;
            ea = 32'h0001_0000 + 32'(p) * 32'h100 + 32'(off);
            mis = exp_misal(sz, off);
            @(negedge clk);
            req_valid = 1'b1; req_store = st[0]; req_size = sz[1:0];
            req_signed = sg[0]; req_use_index = md[0];
            store_src = src_pat[p]; mem_rdata = rd_pat[p];
            imm_disp = imm_pat[p];
            imm_ext = {{20{imm_pat[p][11]}}, imm_pat[p]};
            index_val = 32'hFFFF_F000 + 32'(p) * 5;
            base_val = md ? ea - index_val : ea - imm_ext;
            #1;
            // R1: effective address in both modes
            chk(mem_addr == ea, "R1 address", mem_addr, ea);
            // R2: size-dependent alignment rule
            chk(align_fault == mis, "R2 fault", 32'(align_fault), 32'(mis));
            if (sz == 0)      begin exp_wd = {4{src_pat[p][7:0]}};  exp_be = 4'b0001 << off; end
            else if (sz == 1) begin exp_wd = {2{src_pat[p][15:0]}}; exp_be = 4'b0011 << (2 * (off / 2)); end
            else              begin exp_wd = src_pat[p];            exp_be = 4'b1111; end
            if (st == 0 || mis) begin
                // R6: no strobes on loads or faulted stores
                chk(mem_be == 4'b0, "R6 strobes off", 32'(mem_be), 0);
            end else if (sz == 0) begin
                chk(mem_be == exp_be, "R3 byte strobe", 32'(mem_be), 32'(exp_be));
                chk(mem_wdata == exp_wd, "R3 byte data", mem_wdata, exp_wd);
            end else if (sz == 1) begin
                chk(mem_be == exp_be, "R4 half strobe", 32'(mem_be), 32'(exp_be));
                chk(mem_wdata == exp_wd, "R4 half data", mem_wdata, exp_wd);
            end else begin
                chk(mem_be == exp_be, "R5 word strobe", 32'(mem_be), 32'(exp_be));
                chk(mem_wdata == exp_wd, "R5 word data", mem_wdata, exp_wd);
            end
            @(posedge clk); #2;
            if (st == 1) begin
                chk(rsp_valid == 1'b0, "R10 no rsp after store", 32'(rsp_valid), 0);
            end else begin
                logic [31:0] ev;
                ev = mis ? 32'h0 : exp_load(sz, off, sg[0], rd_pat[p]);
                chk(rsp_valid == 1'b1, "R10 rsp after load", 32'(rsp_valid), 1);
                chk(rsp_fault == mis, "R10 rsp fault", 32'(rsp_fault), 32'(mis));
                if (mis)          chk(rsp_data == ev, "R10 faulted data", rsp_data, ev);
                else if (sz == 0) chk(rsp_data == ev, "R7 byte load", rsp_data, ev);
                else if (sz == 1) chk(rsp_data == ev, "R8 half load", rsp_data, ev);
                else              chk(rsp_data == ev, "R9 word load", rsp_data, ev);
            end
        end

        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk); #2;
        chk(rsp_valid == 1'b0, "R10 drop after idle", 32'(rsp_valid), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'(0), 32'(1));
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule